// File: doc/BRIEF.md
# Fractional-N Clock Generator for General-Purpose Pins

This block holds a small set of phase-accumulator clock generators, four by default. Each generator has a 32-bit increment. On every core clock cycle the increment is added to a 32-bit accumulator, and the top bit of the accumulator is the generator's square-wave output. The output frequency is therefore the core clock frequency times the increment divided by 2^32. Writing an increment of zero parks the generator with its output low. The next nonzero write starts it again from a cleared accumulator.

Each general-purpose pin carries two configuration fields: a 2-bit generator select and a clock-generate flag. A pin with both its output enable and its clock-generate flag set drives the selected generator's square wave. Any other pin passes its ordinary data bit through unchanged. Software reaches the increments and the per-pin fields through a single-cycle write port.

Top module: `fracn_clkgen`

## Requirements
- R1: Reset clears every increment, every accumulator and every pin's select and clock-generate fields. After reset, every pin drives its data input, and a pin later placed in clock mode drives 0 until its generator is given a nonzero increment.
- R2: While its stored increment is nonzero, each generator adds the increment to its 32-bit accumulator on every clock, with wrap-around, and outputs the accumulator's bit 31. An increment of 2^29 written from the halted state gives a period of 8 cycles. The output is low for the first 4 samples after the write edge and high for the next 4.
- R3: The output frequency equals the clock frequency times the increment divided by 2^32. An increment of 2^26 gives exactly 16 rising edges in the 1024 cycles after the write.
- R4: With a stored increment of 0, the generator output is low and the accumulator keeps its value.
- R5: A nonzero write to a generator whose stored increment is 0 clears the accumulator at the write edge, so the output sequence restarts from its beginning.
- R6: Bit 31 of a written increment is ignored, which keeps increments at or below 2^31-1. Writing 0x8000_0000 leaves the generator halted.
- R7: A configuration write (`wr_cfg`=1) to pin `wr_idx` stores `wr_data[1:0]` as the generator select and `wr_data[2]` as the clock-generate flag. The pin then follows the generator whose index equals the select value.
- R8: A pin drives its generator's clock only when its output enable and its clock-generate flag are both 1. In every other case `pin_out` equals `pin_dat` for that pin.
- R9: A write of a new nonzero increment to a running generator does not restart it. At the write edge the accumulator adds the old increment. From the next cycle on it adds the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_cfg | input | 1 | 0: write a generator increment; 1: write a pin configuration |
| wr_idx | input | IDX_W (4) | Generator index or pin index |
| wr_data | input | ACC_W (32) | Increment value, or {clock-generate, select[1:0]} in bits 2:0 |
| pin_dat | input | NUM_PINS (16) | Ordinary output data per pin |
| pin_oe | input | NUM_PINS (16) | Output enable per pin |
| pin_out | output | NUM_PINS (16) | Per-pin output value |

## Verification
The bench checks four corner cases.
- Restart after halt. The waveform is expected to begin from a cleared accumulator. A design that resumed from the held value would show a shifted waveform.
- Retune of a running generator. The phase is expected to continue. A design that cleared the accumulator on every write would delay the next high phase.
- Bit 31 of the increment. A design that kept bit 31 would start a halted generator on a write of 0x8000_0000.
- The two gating bits of a pin. Each is set alone, and a design that decoded only one of them would put a clock on a pin that should pass data.

A frequency count over 1024 cycles and a per-cycle reference comparison across all four generators catch errors in the increment arithmetic and in the select decoding.

// File: rtl/fracn_clkgen.sv
module fracn_clkgen #(
  parameter int NUM_GEN  = 4,
  parameter int NUM_PINS = 16,
  parameter int ACC_W    = 32,
  localparam int SEL_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
  localparam int IDX_W   = (NUM_PINS > NUM_GEN) ? $clog2(NUM_PINS) : $clog2(NUM_GEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_cfg,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ACC_W-1:0]    wr_data,
  input  logic [NUM_PINS-1:0] pin_dat,
  input  logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out
);

  logic [NUM_GEN-1:0][ACC_W-1:0]  n_q;
  logic [NUM_GEN-1:0][ACC_W-1:0]  acc_q;
  logic [NUM_GEN-1:0]             gen_clk;
  logic [NUM_PINS-1:0][SEL_W-1:0] sel_q;
  logic [NUM_PINS-1:0]            cg_q;

  wire [ACC_W-1:0] wr_n = {1'b0, wr_data[ACC_W-2:0]};

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    wire hit = wr_en && !wr_cfg && (wr_idx == IDX_W'(g));
    wire halted = (n_q[g] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        n_q[g]   <= '0;
        acc_q[g] <= '0;
      end else begin
        if (hit) n_q[g] <= wr_n;
        if (hit && halted && wr_n != '0) acc_q[g] <= '0;
        else if (!halted)                acc_q[g] <= acc_q[g] + n_q[g];
      end
    end

    assign gen_clk[g] = acc_q[g][ACC_W-1] && !halted;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    wire hit = wr_en && wr_cfg && (wr_idx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[p] <= '0;
        cg_q[p]  <= 1'b0;
      end else if (hit) begin
        sel_q[p] <= wr_data[SEL_W-1:0];
        cg_q[p]  <= wr_data[SEL_W];
      end
    end

    assign pin_out[p] = (pin_oe[p] && cg_q[p]) ? gen_clk[sel_q[p]] : pin_dat[p];
  end

endmodule

// File: rtl/fracn_clkgen_chk.sv
module fracn_clkgen_chk #(
  parameter int NUM_GEN  = 4,
  parameter int NUM_PINS = 16,
  parameter int ACC_W    = 32,
  localparam int SEL_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
  localparam int IDX_W   = (NUM_PINS > NUM_GEN) ? $clog2(NUM_PINS) : $clog2(NUM_GEN)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           wr_cfg,
  input logic [IDX_W-1:0]               wr_idx,
  input logic [ACC_W-1:0]               wr_data,
  input logic [NUM_PINS-1:0]            pin_dat,
  input logic [NUM_PINS-1:0]            pin_oe,
  input logic [NUM_PINS-1:0]            pin_out,
  input logic [NUM_GEN-1:0][ACC_W-1:0]  n_q,
  input logic [NUM_GEN-1:0][ACC_W-1:0]  acc_q,
  input logic [NUM_PINS-1:0][SEL_W-1:0] sel_q,
  input logic [NUM_PINS-1:0]            cg_q
);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gchk
    wire hit = wr_en && !wr_cfg && (wr_idx == IDX_W'(g));
    wire wr_nz = (wr_data[ACC_W-2:0] != '0);

    a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (n_q[g] != '0) |=> (acc_q[g] == $past(acc_q[g]) + $past(n_q[g])));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (n_q[g] == '0 && !(hit && wr_nz)) |=> $stable(acc_q[g]));

    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && n_q[g] == '0 && wr_nz) |=> (acc_q[g] == '0));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pchk
    a_r8_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[p] |-> (pin_out[p] == pin_dat[p]));

    a_r4_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[p] && cg_q[p] && n_q[sel_q[p]] == '0) |-> !pin_out[p]);
  end

endmodule

bind fracn_clkgen fracn_clkgen_chk #(
  .NUM_GEN(NUM_GEN), .NUM_PINS(NUM_PINS), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
  .wr_data(wr_data), .pin_dat(pin_dat), .pin_oe(pin_oe), .pin_out(pin_out),
  .n_q(n_q), .acc_q(acc_q), .sel_q(sel_q), .cg_q(cg_q)
);

// File: tb/test_fracn_clkgen.sv
`timescale 1ns/1ps
module test_fracn_clkgen;
  localparam int NG = 4;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_cfg = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [NP-1:0] pin_dat = '0;
  logic [NP-1:0] pin_oe = '0;
  logic [NP-1:0] pin_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fracn_clkgen i_fracn_clkgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_idx(wr_idx),
    .wr_data(wr_data), .pin_dat(pin_dat), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // Reference model built from the requirements
  logic [31:0] m_n   [NG];
  logic [31:0] m_acc [NG];
  logic [1:0]  m_sel [NP];
  logic        m_cg  [NP];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_n[g] = '0; m_acc[g] = '0; end
      for (int p = 0; p < NP; p++) begin m_sel[p] = '0; m_cg[p] = 1'b0; end
    end else begin
      for (int g = 0; g < NG; g++) begin
        logic [31:0] nv;
        nv = {1'b0, wr_data[30:0]};
        if (wr_en && !wr_cfg && wr_idx == 4'(g) && m_n[g] == 0 && nv != 0) m_acc[g] = '0;
        else if (m_n[g] != 0) m_acc[g] = m_acc[g] + m_n[g];
        if (wr_en && !wr_cfg && wr_idx == 4'(g)) m_n[g] = nv;
      end
      if (wr_en && wr_cfg) begin
        m_sel[wr_idx] = wr_data[1:0];
        m_cg[wr_idx]  = wr_data[2];
      end
    end
  end

  function automatic logic [NP-1:0] model_out();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      logic gc;
      gc = m_acc[m_sel[p]][31] && (m_n[m_sel[p]] != 0);
      r[p] = (pin_oe[p] && m_cg[p]) ? gc : pin_dat[p];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr_n(input int g, input logic [31:0] v);
    wr_en = 1'b1; wr_cfg = 1'b0; wr_idx = 4'(g); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_pin(input int p, input logic [1:0] sel, input logic cg);
    wr_en = 1'b1; wr_cfg = 1'b1; wr_idx = 4'(p); wr_data = {29'd0, cg, sel};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_model(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, 32'(pin_out), 32'(model_out()));
    end
  endtask

  task automatic t_reset();
    pin_dat = 16'hA5C3; pin_oe = '1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins pass data after reset", 32'(pin_out), 32'h0000A5C3);
    wr_pin(0, 2'd0, 1'b1);
    chk("R1 clock pin low with zero increment", 32'(pin_out[0]), 0);
    run_model(4, "R1 idle model");
  endtask

  task automatic t_period();
    wr_n(0, 32'h2000_0000);
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2 period-8 pattern", 32'(pin_out[0]), 32'((k % 8) >= 4));
    end
  endtask

  task automatic t_halt_restart();
    wr_n(0, 32'h0);
    for (int k = 0; k < 6; k++) begin
      chk("R4 halted output low", 32'(pin_out[0]), 0);
      @(negedge clk);
    end
    wr_n(0, 32'h2000_0000);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk("R5 restart from cleared accumulator", 32'(pin_out[0]), 32'((k % 8) >= 4));
    end
    wr_n(0, 32'h0);
  endtask

  task automatic t_msb_ignored();
    wr_n(0, 32'h8000_0000);
    for (int k = 0; k < 8; k++) begin
      chk("R6 bit 31 alone keeps generator halted", 32'(pin_out[0]), 0);
      @(negedge clk);
    end
    wr_n(0, 32'h0);
    wr_n(0, 32'hA000_0000);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      chk("R6 bit 31 dropped from increment", 32'(pin_out[0]), 32'((k % 8) >= 4));
    end
    wr_n(0, 32'h0);
  endtask

  task automatic t_freq();
    int rises = 0;
    logic prev;
    wr_n(0, 32'h0400_0000);
    prev = pin_out[0];
    for (int k = 1; k < 1024; k++) begin
      @(negedge clk);
      if (pin_out[0] && !prev) rises++;
      prev = pin_out[0];
    end
    chk("R3 rising edges in 1024 cycles", 32'(rises), 16);
    wr_n(0, 32'h0);
  endtask

  task automatic t_retune();
    wr_pin(2, 2'd2, 1'b1);
    wr_n(2, 32'h2000_0000);
    @(negedge clk);
    wr_n(2, 32'h4000_0000);
    for (int k = 0; k < 8; k++) begin
      logic e;
      if (k > 0) @(negedge clk);
      e = ((k % 4) == 1) || ((k % 4) == 2);
      chk("R9 retune keeps phase", 32'(pin_out[2]), 32'(e));
    end
    wr_n(2, 32'h0);
  endtask

  task automatic t_select();
    for (int p = 4; p < 8; p++) wr_pin(p, 2'(p - 4), 1'b1);
    wr_n(0, 32'h2000_0000);
    wr_n(1, 32'h4000_0000);
    wr_n(2, 32'h1234_5678);
    wr_n(3, 32'h7FFF_FFFF);
    run_model(64, "R7 per-pin generator select");
    wr_pin(5, 2'd3, 1'b1);
    run_model(32, "R7 reselect");
  endtask

  task automatic t_gate();
    pin_dat = 16'h0000;
    pin_oe[8] = 1'b0; wr_pin(8, 2'd1, 1'b1);
    pin_oe[9] = 1'b1; wr_pin(9, 2'd1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      pin_dat[8] = k[0]; pin_dat[9] = k[1];
      #0.5;
      chk("R8 oe low passes data", 32'(pin_out[8]), 32'(k[0]));
      chk("R8 clock-generate low passes data", 32'(pin_out[9]), 32'(k[1]));
      @(negedge clk);
    end
    pin_oe[8] = 1'b1;
    run_model(16, "R8 both bits set");
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_period();
    t_halt_restart();
    t_msb_ignored();
    t_freq();
    t_retune();
    t_select();
    t_gate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule